// File: doc/BRIEF.md
# Power-On Reset Stretcher with Domain Cascade

This block turns a raw power-on reset request and an asynchronous power-good level from an always-on domain into a clean root reset for the chip. The power-good level is first brought into the local clock domain by a short synchroniser chain. A stability counter then requires an unbroken run of high samples before it lets the root reset go. Any low sample clears the run and raises the root reset again on the same edge.

A scan reset forces the same state as power-on reset, but only while scan mode is on. The root reset feeds a chain of derived domain resets. Each domain is held while its parent is held and is released a fixed number of edges after its parent. Every reset has a matching enable indication for an alert handler, driven by its own flop, that follows the reset level exactly.

All reset assertion is asynchronous and all release is synchronous to the clock. The block has no reset input of its own apart from the power-on request and the qualified scan reset. None of its outputs feeds back into it.

Top module: `por_stretcher`

## Requirements
- R1: While `por_i` is high, `root_rst_o`, every bit of `dom_rst_o`, `root_rst_en_o` and every bit of `dom_rst_en_o` read 1.
- R2: With `pwr_good_i` held high, `root_rst_o` drops after rising edge STABLE_CYCLES+2 counted from the release of `por_i`. The 2 is the synchroniser depth. It is still high after edge STABLE_CYCLES+1.
- R3: One low sample of the synchronised power-good raises `root_rst_o` at that edge, which is the third edge after `pwr_good_i` falls. Release then needs a fresh full run of STABLE_CYCLES high samples.
- R4: With `scan_mode_i`=1, `scan_rst_i`=1 asserts every reset output at once, without waiting for a clock edge. With `scan_mode_i`=0, `scan_rst_i` has no effect on any output.
- R5: Domain bit i of `dom_rst_o` is high whenever its parent is high. The parent of bit 0 is the root reset, and the parent of bit i is bit i-1. Bit i drops DOM_STAGES*(i+1) edges after the root drops.
- R6: `root_rst_en_o` equals `root_rst_o`, and each bit of `dom_rst_en_o` equals the same bit of `dom_rst_o`, in every cycle.
- R7: When the root reasserts on a clock edge, every domain reset is high after that same edge.
- R8: If `pwr_good_i` stays low when `por_i` is released, every reset output stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Destination clock |
| por_i | input | 1 | Raw power-on reset request, active high, asynchronous |
| pwr_good_i | input | 1 | Power-good level from the always-on domain, asynchronous |
| scan_mode_i | input | 1 | Scan mode qualifier |
| scan_rst_i | input | 1 | Scan reset, active high, used only in scan mode |
| root_rst_o | output | 1 | Stretched root reset, active high |
| root_rst_en_o | output | 1 | Alert-handler enable indication for the root reset |
| dom_rst_o | output | NUM_DOMAINS | Cascaded domain resets, active high |
| dom_rst_en_o | output | NUM_DOMAINS | Alert-handler enable indications, one per domain |

## Verification
A steady high power-good after release pins the exact release edge of the root and of each domain. This separates an off-by-one in the counter, the synchroniser depth or the cascade stage count. A single-cycle power-good glitch shows whether the run restarts from zero rather than resuming, and on which edge the root comes back. A held-low power-good and a scan reset applied with and without scan mode show that the release is gated and that the scan reset is qualified. A long random power-good stream with rare drops is checked edge by edge against a bench model of run length and cascade delay, which tests restart behaviour near the threshold.

// File: rtl/por_stretch_pkg.sv
package por_stretch_pkg;
  parameter int unsigned DEF_STABLE_CYCLES = 32;
  parameter int unsigned DEF_NUM_DOMAINS   = 3;
  parameter int unsigned DEF_SYNC_STAGES   = 2;
  parameter int unsigned DEF_DOM_STAGES    = 2;

  function automatic int unsigned run_cnt_width(int unsigned limit);
    return $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/por_pg_sync.sv
module por_pg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_i,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], async_i};
  end

  assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/por_stable_cnt.sv
module por_stable_cnt #(
  parameter int unsigned STABLE = 32,
  parameter int unsigned CW     = 6
) (
  input  logic clk_i,
  input  logic arst_i,
  input  logic pg_sync_i,
  output logic root_rst_o,
  output logic root_en_o
);
  localparam logic [CW-1:0] FULL = CW'(STABLE);

  logic [CW-1:0] run_q;
  logic          root_q;
  logic          en_q;

  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i) begin
      run_q  <= '0;
      root_q <= 1'b1;
      en_q   <= 1'b1;
    end else if (!pg_sync_i) begin
      run_q  <= '0;
      root_q <= 1'b1;
      en_q   <= 1'b1;
    end else if (run_q != FULL) begin
      run_q  <= run_q + 1'b1;
      root_q <= (run_q + 1'b1) != FULL;
      en_q   <= (run_q + 1'b1) != FULL;
    end
  end

  assign root_rst_o = root_q;
  assign root_en_o  = en_q;

  assert_run_bounded_R2: assert property (@(posedge clk_i) disable iff (arst_i)
    run_q <= FULL);
  assert_release_full_run_R2: assert property (@(posedge clk_i) disable iff (arst_i)
    $fell(root_q) |-> (run_q == FULL));
  assert_low_sample_reasserts_R3: assert property (@(posedge clk_i) disable iff (arst_i)
    !pg_sync_i |=> (root_q && run_q == '0));
  assert_root_en_tracks_R6: assert property (@(posedge clk_i) disable iff (arst_i)
    en_q == root_q);
endmodule

// File: rtl/por_dom_cascade.sv
module por_dom_cascade #(
  parameter int unsigned NUM    = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic           clk_i,
  input  logic           arst_i,
  input  logic           root_rst_i,
  output logic [NUM-1:0] dom_rst_o,
  output logic [NUM-1:0] dom_en_o
);
  logic [NUM-1:0] parent_w;

  for (genvar g = 0; g < NUM; g++) begin : g_dom
    logic [STAGES-1:0] chain_q;
    logic              en_q;

    if (g == 0) begin : g_first
      assign parent_w[g] = root_rst_i;
    end else begin : g_next
      assign parent_w[g] = dom_rst_o[g-1];
    end

    always_ff @(posedge clk_i or posedge parent_w[g]) begin
      if (parent_w[g]) begin
        chain_q <= '1;
        en_q    <= 1'b1;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], 1'b0};
        en_q    <= chain_q[STAGES-2];
      end
    end

    assign dom_rst_o[g] = chain_q[STAGES-1];
    assign dom_en_o[g]  = en_q;

    assert_child_held_R5: assert property (@(posedge clk_i) disable iff (arst_i)
      parent_w[g] |-> dom_rst_o[g]);
    assert_child_after_parent_R5: assert property (@(posedge clk_i) disable iff (arst_i)
      $fell(dom_rst_o[g]) |-> (!parent_w[g] && $past(!parent_w[g])));
    assert_dom_en_tracks_R6: assert property (@(posedge clk_i) disable iff (arst_i)
      dom_en_o[g] == dom_rst_o[g]);
  end
endmodule

// File: rtl/por_stretcher.sv
module por_stretcher
  import por_stretch_pkg::*;
#(
  parameter int unsigned STABLE_CYCLES  = DEF_STABLE_CYCLES,
  parameter int unsigned NUM_DOMAINS    = DEF_NUM_DOMAINS,
  parameter int unsigned PG_SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned DOM_STAGES     = DEF_DOM_STAGES
) (
  input  logic                   clk_i,
  input  logic                   por_i,
  input  logic                   pwr_good_i,
  input  logic                   scan_mode_i,
  input  logic                   scan_rst_i,
  output logic                   root_rst_o,
  output logic                   root_rst_en_o,
  output logic [NUM_DOMAINS-1:0] dom_rst_o,
  output logic [NUM_DOMAINS-1:0] dom_rst_en_o
);
  localparam int unsigned CW = run_cnt_width(STABLE_CYCLES);

  logic hard_rst;
  logic pg_sync;

  // Only the power-on request and the scan-qualified scan reset clear this block
  assign hard_rst = por_i | (scan_mode_i & scan_rst_i);

  por_pg_sync #(.STAGES(PG_SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .arst_i  (hard_rst),
    .async_i (pwr_good_i),
    .sync_o  (pg_sync)
  );

  por_stable_cnt #(.STABLE(STABLE_CYCLES), .CW(CW)) u_cnt (
    .clk_i      (clk_i),
    .arst_i     (hard_rst),
    .pg_sync_i  (pg_sync),
    .root_rst_o (root_rst_o),
    .root_en_o  (root_rst_en_o)
  );

  por_dom_cascade #(.NUM(NUM_DOMAINS), .STAGES(DOM_STAGES)) u_casc (
    .clk_i      (clk_i),
    .arst_i     (hard_rst),
    .root_rst_i (root_rst_o),
    .dom_rst_o  (dom_rst_o),
    .dom_en_o   (dom_rst_en_o)
  );

  assert_scan_forces_all_R4: assert property (@(posedge clk_i) disable iff (por_i)
    (scan_mode_i && scan_rst_i) |-> (root_rst_o && (&dom_rst_o)));
  assert_root_raise_cascades_R7: assert property (@(posedge clk_i) disable iff (hard_rst)
    $rose(root_rst_o) |-> (&dom_rst_o));
endmodule

// File: tb/por_stretcher_tb.sv
module por_stretcher_tb_top;
  localparam int unsigned N  = 32;
  localparam int unsigned ND = 3;
  localparam int unsigned DS = 2;

  logic clk = 1'b0;
  logic por, pg, smode, srst;
  logic root, root_en;
  logic [ND-1:0] dom, dom_en;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  por_stretcher #(.STABLE_CYCLES(N), .NUM_DOMAINS(ND), .PG_SYNC_STAGES(2), .DOM_STAGES(DS)) dut_i (
    .clk_i(clk), .por_i(por), .pwr_good_i(pg), .scan_mode_i(smode), .scan_rst_i(srst),
    .root_rst_o(root), .root_rst_en_o(root_en), .dom_rst_o(dom), .dom_rst_en_o(dom_en)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string tag, input logic exp_root, input logic [ND-1:0] exp_dom);
    chk(tag, root, exp_root);
    chk(tag, root_en, exp_root);
    for (int i = 0; i < ND; i++) begin
      chk(tag, dom[i], exp_dom[i]);
      chk(tag, dom_en[i], exp_dom[i]);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Expected release edge of domain i after the root is let go
  function automatic int unsigned dom_release(input int unsigned root_edge, input int unsigned i);
    return root_edge + DS * (i + 1);
  endfunction

  // Reference model state for the random phase
  logic m_s1, m_s2, m_root;
  int unsigned m_run;
  int unsigned m_low [ND];
  logic [ND-1:0] m_dom;

  task automatic model_edge(input logic pg_in);
    logic old_root;
    logic [ND-1:0] old_dom;
    old_root = m_root;
    old_dom  = m_dom;
    if (!m_s2) begin
      m_run = 0; m_root = 1'b1;
    end else if (m_run < N) begin
      m_run++; m_root = (m_run < N);
    end
    m_s2 = m_s1;
    m_s1 = pg_in;
    for (int i = 0; i < ND; i++) begin
      logic par_old, par_new;
      par_old = (i == 0) ? old_root : old_dom[i-1];
      par_new = (i == 0) ? m_root : m_dom[i-1];
      if (par_old) m_low[i] = 0;
      else if (m_low[i] < DS) m_low[i]++;
      if (par_new) m_low[i] = 0;
      m_dom[i] = (m_low[i] < DS);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    por = 1'b1; pg = 1'b0; smode = 1'b0; srst = 1'b0;
    @(negedge clk);
    repeat (4) tick();
    // R1: reset state
    chk_all("R1", 1'b1, '1);
    pg = 1'b1;
    repeat (3) tick();
    chk_all("R1", 1'b1, '1);

    // R8: power-good low at release keeps everything held
    pg = 1'b0;
    repeat (3) tick();
    por = 1'b0;
    repeat (60) tick();
    chk_all("R8", 1'b1, '1);

    // R2 / R5 / R6: exact release edges with steady power-good
    por = 1'b1;
    tick();
    pg = 1'b1;
    repeat (2) tick();
    por = 1'b0;
    for (int unsigned k = 1; k <= N + 2 + DS * ND + 2; k++) begin
      logic [ND-1:0] ed;
      tick();
      for (int unsigned i = 0; i < ND; i++) ed[i] = (k < dom_release(N + 2, i));
      chk_all((k < N + 2) ? "R2" : "R5", (k < N + 2), ed);
    end

    // R3 / R7: one-cycle glitch on power-good restarts the run
    pg = 1'b0;
    tick();
    pg = 1'b1;
    for (int unsigned j = 1; j <= N + 5; j++) begin
      logic er;
      if (j > 1) tick();
      er = (j >= 3) && (j <= N + 2);
      chk("R3", root, er);
      if (j == 3) chk_all("R7", 1'b1, '1);
    end
    repeat (DS * ND + 2) tick();
    chk_all("R3", 1'b0, '0);

    // R4: scan reset without scan mode is ignored
    srst = 1'b1;
    repeat (10) tick();
    chk_all("R4", 1'b0, '0);
    // R4: with scan mode it asserts everything without a clock edge
    smode = 1'b1;
    #1;
    chk_all("R4", 1'b1, '1);
    @(negedge clk);
    repeat (4) tick();
    chk_all("R4", 1'b1, '1);
    srst = 1'b0;
    for (int unsigned k = 1; k <= N + 2; k++) begin
      tick();
      if (k == N + 1) chk("R4", root, 1'b1);
      if (k == N + 2) chk("R4", root, 1'b0);
    end
    smode = 1'b0;
    repeat (DS * ND + 2) tick();

    // Random power-good stream against the reference model (R2, R3, R5)
    por = 1'b1;
    pg = 1'b0;
    tick();
    m_s1 = 1'b0; m_s2 = 1'b0; m_root = 1'b1; m_run = 0; m_dom = '1;
    for (int i = 0; i < ND; i++) m_low[i] = 0;
    por = 1'b0;
    for (int c = 0; c < 4000; c++) begin
      logic p;
      p = (($urandom % 48) != 0);
      if (c % 700 < 3) p = 1'b0;
      pg = p;
      tick();
      model_edge(p);
      chk("R3", root, m_root);
      chk("R6", root_en, m_root);
      for (int i = 0; i < ND; i++) chk("R5", dom[i], m_dom[i]);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule